// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit performs the shift and rotate family of integer operations for a 64-bit register datapath whose operations may act on 1, 2, 4 or 8 byte operands. Each accepted request carries an opcode, a source operand, a raw count, an operand size, the incoming carry flag and the present value of the destination register. One clock later the unit presents the full 64-bit value to write back, the carry flag that results, and an enable that says whether the flags may be updated.

The count is first narrowed according to the operand size. Plain rotates then reduce it modulo the operand width, and rotates through carry reduce it modulo the width plus one, with the carry acting as an extra bit. A narrowed count of zero leaves the flags alone. A rotate whose reduced count is zero leaves the destination untouched. Otherwise the result is written under the partial-register rule: narrow results keep the upper bytes of the old destination, and wide results clear them.

Top module: `shrot_unit`

## Requirements
- R1: A request presented with `in_valid_i` high gives `out_valid_o` high exactly one clock later. Cycles without a request give `out_valid_o` low and leave `result_o`, `cf_o` and `flags_we_o` unchanged. Reset clears all outputs.
- R2: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes, so the width W is 8, 16, 32 or 64. The masked count is `count_i[5:0]` for size code 3 and `count_i[4:0]` for every other size. Higher count bits have no effect.
- R3: Opcode 0 is a logical left shift by the masked count n. The low W bits are `operand << n`, and the carry is operand bit W-n, or 0 when n > W.
- R4: Opcode 1 is a logical right shift by n. The vacated bits are filled with zeros, and the carry is operand bit n-1, or 0 when n > W.
- R5: Opcode 2 is an arithmetic right shift by n. The vacated bits are filled with operand bit W-1, and the carry is the last bit shifted out, which is the sign bit when n > W.
- R6: Opcodes 3 (rotate left) and 4 (rotate right) rotate the W-bit operand by n mod W. The carry is result bit 0 for a left rotate and result bit W-1 for a right rotate.
- R7: Opcodes 5 (left) and 6 (right) rotate the (W+1)-bit value formed by the carry above the operand by n mod (W+1). The new carry is the top bit of the rotated value.
- R8: When the masked count is zero, `flags_we_o` is 0 and `cf_o` equals the incoming carry.
- R9: When a rotate's reduced count is zero, `result_o` equals the old destination in all 64 bits. If the masked count is nonzero, `flags_we_o` is still 1.
- R10: In every other case the result is merged as follows. Sizes 1 and 2 bytes replace only the low 8 or 16 bits of the old destination. Sizes 4 and 8 bytes zero-extend the W-bit result to 64 bits.
- R11: Opcode 7 is a no-operation. `result_o` equals the old destination, `flags_we_o` is 0 and `cf_o` equals the incoming carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request valid |
| op_i | input | 3 | Operation code (0..7) |
| size_i | input | 2 | Operand size code |
| operand_i | input | 64 | Source value to shift or rotate |
| count_i | input | 8 | Raw count |
| cf_i | input | 1 | Incoming carry flag |
| old_dest_i | input | 64 | Current destination register value |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Value to write to the destination |
| cf_o | output | 1 | Resulting carry flag |
| flags_we_o | output | 1 | Flags may be updated |

## Verification
The properties assume that every input is a known value whenever `in_valid_i` is high, and that a request's effect appears only in the cycle after it. The properties that concern the upper-byte merge are limited to shift opcodes, because a rotate with a reduced count of zero legitimately returns the whole old destination. The stimulus takes every opcode, including the no-operation code, and every size. It uses full 8-bit counts, so the masked-off bits vary. It also draws small counts often enough to hit the zero, width and width-plus-one boundaries.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int XLEN    = 64;
    localparam int SHAMT_W = 7;   // holds 0..64 and 65

    typedef logic [XLEN-1:0]    word_t;
    typedef logic [SHAMT_W-1:0] shamt_t;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_NOP = 3'd7
    } shrot_op_e;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } shrot_sz_e;

    typedef struct packed {
        logic [5:0] masked;   // size-dependent masked count
        shamt_t     rot_e;    // masked mod W
        shamt_t     rcx_e;    // masked mod (W+1)
        shamt_t     width;    // W in bits
        logic       nonzero;  // masked != 0
    } cnt_info_t;

    typedef struct packed {
        word_t value;         // W-bit result, zero above W
        logic  carry;
        logic  keep_old;      // destination stays unchanged
    } core_res_t;

    function automatic shamt_t op_width(input shrot_sz_e sz);
        case (sz)
            SZ_B1:   return shamt_t'(8);
            SZ_B2:   return shamt_t'(16);
            SZ_B4:   return shamt_t'(32);
            default: return shamt_t'(64);
        endcase
    endfunction

    function automatic word_t width_mask(input shrot_sz_e sz);
        case (sz)
            SZ_B1:   return word_t'(64'h0000_0000_0000_00FF);
            SZ_B2:   return word_t'(64'h0000_0000_0000_FFFF);
            SZ_B4:   return word_t'(64'h0000_0000_FFFF_FFFF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/shrot_count.sv
module shrot_count
    import shrot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  shrot_sz_e        size_i,
    input  logic [CNT_W-1:0] count_i,
    output cnt_info_t        info_o
);
    shamt_t m7;

    always_comb begin
        info_o.width = op_width(size_i);
        if (size_i == SZ_B8)
            info_o.masked = count_i[5:0];
        else
            info_o.masked = {1'b0, count_i[4:0]};
        m7 = {1'b0, info_o.masked};
        info_o.nonzero = |info_o.masked;
        // widths are powers of two: mod W is a mask
        info_o.rot_e = m7 & (info_o.width - shamt_t'(1));
        case (size_i)
            SZ_B1:   info_o.rcx_e = m7 % shamt_t'(9);
            SZ_B2:   info_o.rcx_e = m7 % shamt_t'(17);
            default: info_o.rcx_e = m7;   // masked count already below W+1
        endcase
    end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
    import shrot_pkg::*;
(
    input  shrot_op_e op_i,
    input  shrot_sz_e size_i,
    input  word_t     operand_i,
    input  logic      cf_i,
    input  cnt_info_t info_i,
    output core_res_t res_o
);
    word_t                msk;
    word_t                a;
    word_t                se;
    word_t                rot;
    shamt_t               w;
    shamt_t               n;
    logic [5:0]           w_m1;
    logic [2*XLEN-1:0]    t;
    logic [XLEN:0]        v;
    logic [XLEN:0]        m65;
    logic [XLEN:0]        x;

    always_comb begin
        msk   = width_mask(size_i);
        a     = operand_i & msk;
        w     = info_i.width;
        w_m1  = 6'(w - shamt_t'(1));
        n     = {1'b0, info_i.masked};
        se    = a | (~msk & {XLEN{a[w_m1]}});
        t     = '0;
        rot   = '0;
        v     = ({1'b0, a}) | ((XLEN+1)'(cf_i) << w);
        m65   = ((XLEN+1)'(1) << (w + shamt_t'(1))) - (XLEN+1)'(1);
        x     = '0;
        res_o = '{value: '0, carry: cf_i, keep_old: 1'b0};

        case (op_i)
            OP_SHL: begin
                t = {{XLEN{1'b0}}, a} << n;
                res_o.value = t[XLEN-1:0] & msk;
                res_o.carry = t[w];
            end
            OP_SHR: begin
                t = {a, {XLEN{1'b0}}} >> n;
                res_o.value = t[2*XLEN-1:XLEN];
                res_o.carry = t[XLEN-1];
            end
            OP_SAR: begin
                t = $unsigned($signed({se, {XLEN{1'b0}}}) >>> n);
                res_o.value = t[2*XLEN-1:XLEN] & msk;
                res_o.carry = t[XLEN-1];
            end
            OP_ROL: begin
                rot = ((a << info_i.rot_e) | (a >> (w - info_i.rot_e))) & msk;
                res_o.value    = rot;
                res_o.carry    = rot[0];
                res_o.keep_old = (info_i.rot_e == '0);
            end
            OP_ROR: begin
                rot = ((a >> info_i.rot_e) | (a << (w - info_i.rot_e))) & msk;
                res_o.value    = rot;
                res_o.carry    = rot[w_m1];
                res_o.keep_old = (info_i.rot_e == '0);
            end
            OP_RCL: begin
                x = ((v << info_i.rcx_e)
                     | (v >> (w + shamt_t'(1) - info_i.rcx_e))) & m65;
                res_o.value    = x[XLEN-1:0] & msk;
                res_o.carry    = x[w];
                res_o.keep_old = (info_i.rcx_e == '0);
            end
            OP_RCR: begin
                x = ((v >> info_i.rcx_e)
                     | (v << (w + shamt_t'(1) - info_i.rcx_e))) & m65;
                res_o.value    = x[XLEN-1:0] & msk;
                res_o.carry    = x[w];
                res_o.keep_old = (info_i.rcx_e == '0);
            end
            default: begin
                res_o.keep_old = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/shrot_merge.sv
module shrot_merge
    import shrot_pkg::*;
(
    input  shrot_sz_e size_i,
    input  word_t     old_i,
    input  word_t     value_i,
    input  logic      keep_i,
    output word_t     dest_o
);
    always_comb begin
        if (keep_i)
            dest_o = old_i;
        else begin
            case (size_i)
                SZ_B1:   dest_o = {old_i[XLEN-1:8],  value_i[7:0]};
                SZ_B2:   dest_o = {old_i[XLEN-1:16], value_i[15:0]};
                default: dest_o = value_i;   // already zero above W
            endcase
        end
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid_i,
    input  logic [2:0]       op_i,
    input  logic [1:0]       size_i,
    input  logic [63:0]      operand_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             cf_i,
    input  logic [63:0]      old_dest_i,
    output logic             out_valid_o,
    output logic [63:0]      result_o,
    output logic             cf_o,
    output logic             flags_we_o
);
    shrot_op_e op;
    shrot_sz_e sz;
    cnt_info_t info;
    core_res_t core;
    word_t     merged;
    logic      we_d;
    logic      cf_d;

    assign op = shrot_op_e'(op_i);
    assign sz = shrot_sz_e'(size_i);

    shrot_count #(.CNT_W(CNT_W)) u_count (
        .size_i  (sz),
        .count_i (count_i),
        .info_o  (info)
    );

    shrot_core u_core (
        .op_i      (op),
        .size_i    (sz),
        .operand_i (operand_i),
        .cf_i      (cf_i),
        .info_i    (info),
        .res_o     (core)
    );

    shrot_merge u_merge (
        .size_i  (sz),
        .old_i   (old_dest_i),
        .value_i (core.value),
        .keep_i  (core.keep_old),
        .dest_o  (merged)
    );

    assign we_d = info.nonzero && (op != OP_NOP);
    assign cf_d = we_d ? core.carry : cf_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
            cf_o        <= 1'b0;
            flags_we_o  <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                result_o   <= merged;
                cf_o       <= cf_d;
                flags_we_o <= we_d;
            end
        end
    end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid_i,
    input logic [2:0]       op_i,
    input logic [1:0]       size_i,
    input logic [CNT_W-1:0] count_i,
    input logic             cf_i,
    input logic [63:0]      old_dest_i,
    input logic             out_valid_o,
    input logic [63:0]      result_o,
    input logic             cf_o,
    input logic             flags_we_o
);
    logic cnt_zero;
    logic is_rot;
    logic is_shift;

    // R2: masked count zero, 6 bits for the 8-byte size, else 5 bits
    assign cnt_zero = (size_i == 2'd3) ? (count_i[5:0] == 6'd0)
                                       : (count_i[4:0] == 5'd0);
    assign is_rot   = (op_i >= 3'd3) && (op_i <= 3'd6);
    assign is_shift = (op_i <= 3'd2);

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid_o == $past(in_valid_i)));

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> ($stable(result_o) && $stable(cf_o) && $stable(flags_we_o)));

    assert_zero_count_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && cnt_zero) |=> (!flags_we_o && (cf_o == $past(cf_i))));

    assert_rot_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && is_rot && cnt_zero) |=> (result_o == $past(old_dest_i)));

    assert_merge_b1_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && is_shift && size_i == 2'd0)
        |=> (result_o[63:8] == $past(old_dest_i[63:8])));

    assert_zext_b4_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && is_shift && size_i == 2'd2) |=> (result_o[63:32] == 32'd0));

    assert_nop_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && op_i == 3'd7)
        |=> ((result_o == $past(old_dest_i)) && !flags_we_o));

    assert_shl_past_width_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && op_i == 3'd0 && size_i == 2'd0 && count_i[4:0] > 5'd8)
        |=> ((result_o[7:0] == 8'd0) && !cf_o && flags_we_o));
endmodule

bind shrot_unit shrot_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid_i),
    .op_i        (op_i),
    .size_i      (size_i),
    .count_i     (count_i),
    .cf_i        (cf_i),
    .old_dest_i  (old_dest_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o),
    .cf_o        (cf_o),
    .flags_we_o  (flags_we_o)
);

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [63:0] operand_i = '0;
    logic [7:0]  count_i = '0;
    logic        cf_i = 1'b0;
    logic [63:0] old_dest_i = '0;
    logic        out_valid_o;
    logic [63:0] result_o;
    logic        cf_o;
    logic        flags_we_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    shrot_unit u_shrot_unit (
        .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .op_i(op_i),
        .size_i(size_i), .operand_i(operand_i), .count_i(count_i),
        .cf_i(cf_i), .old_dest_i(old_dest_i), .out_valid_o(out_valid_o),
        .result_o(result_o), .cf_o(cf_o), .flags_we_o(flags_we_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0:       return "R3";
            3'd1:       return "R4";
            3'd2:       return "R5";
            3'd3, 3'd4: return "R6";
            3'd5, 3'd6: return "R7";
            default:    return "R11";
        endcase
    endfunction

    // Bit-serial reference built from the requirements
    function automatic void ref_model(
        input  logic [2:0] op, input logic [1:0] sz, input logic [63:0] src,
        input  logic [7:0] cnt, input logic cfi, input logic [63:0] old,
        output logic [63:0] res, output logic cfo, output logic we);
        int w  = 8 << sz;
        int mc = (sz == 2'd3) ? int'(cnt & 8'h3f) : int'(cnt & 8'h1f);   // R2
        int e;
        logic [63:0] msk = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF
                                     : ((64'd1 << w) - 64'd1);
        logic [63:0] r = src & msk;
        logic c = cfi;
        logic b;
        logic keep = 1'b0;
        case (op)
            3'd0: for (int i = 0; i < mc; i++) begin c = r[w-1]; r = (r << 1) & msk; end
            3'd1: for (int i = 0; i < mc; i++) begin c = r[0]; r = r >> 1; end
            3'd2: for (int i = 0; i < mc; i++) begin
                      c = r[0]; r = (r >> 1) | (64'(r[w-1]) << (w-1));
                  end
            3'd3: begin
                      e = mc % w;
                      for (int i = 0; i < e; i++) begin b = r[w-1]; r = ((r << 1) & msk) | 64'(b); end
                      c = r[0]; keep = (e == 0);
                  end
            3'd4: begin
                      e = mc % w;
                      for (int i = 0; i < e; i++) r = (r >> 1) | (64'(r[0]) << (w-1));
                      c = r[w-1]; keep = (e == 0);
                  end
            3'd5: begin
                      e = mc % (w + 1);
                      for (int i = 0; i < e; i++) begin b = r[w-1]; r = ((r << 1) & msk) | 64'(c); c = b; end
                      keep = (e == 0);
                  end
            3'd6: begin
                      e = mc % (w + 1);
                      for (int i = 0; i < e; i++) begin b = r[0]; r = (r >> 1) | (64'(c) << (w-1)); c = b; end
                      keep = (e == 0);
                  end
            default: keep = 1'b1;
        endcase
        we = (op != 3'd7) && (mc != 0);
        if (!we) c = cfi;
        cfo = c;
        if (keep) res = old;
        else case (sz)
            2'd0:    res = {old[63:8], r[7:0]};
            2'd1:    res = {old[63:16], r[15:0]};
            default: res = r;
        endcase
    endfunction

    task automatic run_vec(input logic [2:0] op, input logic [1:0] sz,
                           input logic [63:0] src, input logic [7:0] cnt,
                           input logic cfi, input logic [63:0] old,
                           input string tag);
        logic [63:0] er;
        logic ec, ew;
        ref_model(op, sz, src, cnt, cfi, old, er, ec, ew);
        in_valid_i = 1'b1; op_i = op; size_i = sz; operand_i = src;
        count_i = cnt; cf_i = cfi; old_dest_i = old;
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R1", "out_valid", 64'(out_valid_o), 64'd1);
        check(tag, "result", result_o, er);
        check(tag, "carry", 64'(cf_o), 64'(ec));
        check(tag, "flags_we", 64'(flags_we_o), 64'(ew));
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "reset valid", 64'(out_valid_o), 64'd0);
        check("R1", "reset result", result_o, 64'd0);
        check("R1", "reset flags_we", 64'(flags_we_o), 64'd0);

        // R3 hand-computed: byte shift of 0x81 by 1 merges into old
        in_valid_i = 1'b1; op_i = 3'd0; size_i = 2'd0; operand_i = 64'h81;
        count_i = 8'd1; cf_i = 1'b0; old_dest_i = 64'h1122_3344_5566_7788;
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R3", "hand result", result_o, 64'h1122_3344_5566_7702);
        check("R3", "hand carry", 64'(cf_o), 64'd1);

        // R1: idle cycle keeps outputs
        held = result_o;
        @(negedge clk);
        check("R1", "idle valid", 64'(out_valid_o), 64'd0);
        check("R1", "idle hold", result_o, held);

        // R2: count bits above the mask ignored
        run_vec(3'd0, 2'd3, 64'd1, 8'h41, 1'b0, 64'hdead, "R2");
        check("R2", "8B mask 6 bits", result_o, 64'd2);
        run_vec(3'd0, 2'd0, 64'd1, 8'he1, 1'b0, 64'hff00, "R2");
        check("R2", "1B mask 5 bits", result_o, 64'hff02);
        // R8: masked count zero
        run_vec(3'd1, 2'd0, 64'hff, 8'h20, 1'b1, 64'h55, "R8");
        run_vec(3'd2, 2'd3, 64'hffff, 8'h40, 1'b1, 64'h0, "R8");
        // R9: rotate reduced to zero keeps old
        run_vec(3'd3, 2'd0, 64'h81, 8'd8, 1'b0, 64'hcafe_f00d_1234_5678, "R9");
        run_vec(3'd5, 2'd0, 64'h81, 8'd9, 1'b1, 64'h1111_2222_3333_4444, "R9");
        run_vec(3'd6, 2'd1, 64'h8001, 8'd17, 1'b0, 64'h9999, "R9");
        // R10: merge and zero-extension
        run_vec(3'd1, 2'd1, 64'hffff_ffff_ffff_8000, 8'd4, 1'b0, 64'habcd_ef01_2345_6789, "R10");
        run_vec(3'd0, 2'd2, 64'hffff_ffff_ffff_ffff, 8'd4, 1'b0, 64'habcd_ef01_2345_6789, "R10");
        // R5: sign fill at and beyond the width
        run_vec(3'd2, 2'd1, 64'h8000, 8'd15, 1'b0, 64'h0, "R5");
        run_vec(3'd2, 2'd0, 64'h80, 8'd20, 1'b0, 64'h0, "R5");
        // R4: right shift past the width
        run_vec(3'd1, 2'd0, 64'hff, 8'd9, 1'b1, 64'h0, "R4");
        // R6, R7 boundaries at 64 bits
        run_vec(3'd4, 2'd3, 64'h8000_0000_0000_0001, 8'd63, 1'b0, 64'h0, "R6");
        run_vec(3'd5, 2'd3, 64'h8000_0000_0000_0001, 8'd63, 1'b1, 64'h0, "R7");
        run_vec(3'd6, 2'd2, 64'h1, 8'd31, 1'b1, 64'h0, "R7");
        // R11: no-operation code
        run_vec(3'd7, 2'd2, 64'h1234, 8'd5, 1'b1, 64'h7777_6666_5555_4444, "R11");

        for (int k = 0; k < 3000; k++) begin
            logic [2:0] op;
            logic [7:0] cnt;
            op  = 3'($urandom_range(0, 7));
            cnt = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 18)) : 8'($urandom);
            run_vec(op, 2'($urandom_range(0, 3)), {$urandom, $urandom}, cnt,
                    1'($urandom), {$urandom, $urandom}, op_tag(op));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule